// File: doc/BRIEF.md
# DLL Delay Calibration Sequencer

This block prepares a storage-card host interface for double-data-rate transfers. When software asks for a double-data-rate timing mode, the sequencer switches the data path into DDR mode. It then starts the on-chip delay-locked loop with a fixed configuration and polls the loop's lock flag. When the loop locks, the sequencer turns the locked master value into two sample delays and programs them. If the loop does not lock within the time budget, the sequencer gives up and leaves the delay register untouched.

The sequencer talks to the delay-line logic through a small register port. This port has one write strobe, one read strobe, a two-bit register select, write data, and read data. Read data returns on the clock after the read strobe. The register selects are: 0 for lock status, 1 for loop control, 2 for sample delays and 3 for bus data-mode select. The timeout budget is given in microseconds, together with the number of clock cycles per microsecond.

Top module: `dll_cal_seq`

## Requirements
- R1: A start pulse with `timing_mode_i` equal to 2 or 3 (the DDR modes) is accepted in idle. On the next cycle the sequencer writes register 3 with bit 0 set to 1 (1 = DDR, 0 = SDR). This is the first write of the run.
- R2: The second write goes to register 1 and carries 0x3F0101C8. Its fields are: lock time 0xC8 in bits 7:0, step 1 in bits 15:8, initial value 1 in bits 23:16, clock mode 1 in bit 24, start 1 in bit 25 and bypass time 0xF in bits 29:26.
- R3: After the control write, the sequencer reads register 0 repeatedly, one read every two cycles. It stops when bit 8 of the returned word is 1. It never reads and writes in the same cycle.
- R4: The budget is LIMIT = TIMEOUT_US × CYC_PER_US cycles, counted from the first poll. A check that finds bit 8 low once that many polling cycles have passed ends the run with a `timeout_o` pulse. Register 2 is not written in that run. A lock is honoured if it is seen on the last check before the budget runs out.
- R5: On lock, register 2 is written with the pad delay in bits 7:0 and the pad delay plus one in bits 15:8. The pad delay is bits 7:1 of the lock word. Bits 31:16 are zero.
- R6: `done_o` pulses for one cycle on the cycle after the delay write. `done_o` and `timeout_o` are never high together.
- R7: `busy_o` is high from the cycle after an accepted start up to and including the cycle of the done or timeout pulse. A start pulse seen while busy is ignored.
- R8: A start pulse with any other timing mode (0, 1, 4 to 7) is ignored: no register access and no busy.
- R9: After reset, `busy_o`, `done_o`, `timeout_o` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration request pulse |
| timing_mode_i | input | 3 | Requested timing mode; 2 and 3 are DDR |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_addr_o | output | 2 | Register select |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, valid the cycle after `reg_rd_o` |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Success pulse |
| timeout_o | output | 1 | Lock-timeout pulse |

## Verification
The bench builds the block with CYC_PER_US = 2 and TIMEOUT_US = 10, so the budget is only 20 cycles. This lets the bench sweep the modelled lock latency across the whole success-to-timeout boundary, including the last check that still succeeds. The modelled lock value is swept over all 256 codes, which covers the pad and read delay fields at their extremes. Every non-DDR mode code is also tried, and a second start is sent in the middle of a run.

// File: rtl/dll_cal_pkg.sv
package dll_cal_pkg;

    // Register selects on the delay-line port
    typedef enum logic [1:0] {
        RS_LOCK   = 2'd0,
        RS_CTRL   = 2'd1,
        RS_DELAY  = 2'd2,
        RS_BUSSEL = 2'd3
    } reg_sel_e;

    // Timing mode codes on the request input
    typedef enum logic [2:0] {
        TM_LEGACY  = 3'd0,
        TM_SDR_HS  = 3'd1,
        TM_DDR_UHS = 3'd2,
        TM_DDR_MMC = 3'd3
    } timing_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_BUS,
        ST_WR_CTRL,
        ST_RD_LOCK,
        ST_CHK_LOCK,
        ST_WR_DELAY,
        ST_FIN_OK,
        ST_FIN_TO
    } cal_state_e;

    // Loop control word layout (MSB first)
    typedef struct packed {
        logic [1:0] rsvd;
        logic [3:0] bypass_time;
        logic       start;
        logic       clk_mode;
        logic [7:0] init_val;
        logic [7:0] step;
        logic [7:0] lock_time;
    } dll_ctrl_t;

    // Sample delay word layout (MSB first)
    typedef struct packed {
        logic [15:0] rsvd;
        logic [7:0]  rd_dly;
        logic [7:0]  pad_dly;
    } dll_delay_t;

    localparam logic [31:0] BUSSEL_DDR = 32'h0000_0001;
    localparam int          LOCK_FLAG_BIT = 8;

    function automatic logic is_ddr_mode(input logic [2:0] m);
        return (m == TM_DDR_UHS) || (m == TM_DDR_MMC);
    endfunction

    function automatic dll_ctrl_t ctrl_word();
        dll_ctrl_t c;
        c.rsvd        = 2'b00;
        c.bypass_time = 4'hF;
        c.start       = 1'b1;
        c.clk_mode    = 1'b1;
        c.init_val    = 8'h01;
        c.step        = 8'h01;
        c.lock_time   = 8'hC8;
        return c;
    endfunction

endpackage

// File: rtl/dll_poll_timer.sv
module dll_poll_timer #(
    parameter int LIMIT = 400000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q < LIMIT_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q >= LIMIT_C);

    // Counter saturates at the budget
    p_cnt_sat_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT_C);

    // Clear brings the count back to zero
    p_clr_zero_r4: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !expired_o);

endmodule

// File: rtl/dll_delay_calc.sv
module dll_delay_calc
    import dll_cal_pkg::*;
(
    input  logic [7:0]  lock_val_i,
    output logic [31:0] delay_word_o
);
    dll_delay_t d;
    logic       unused_lock_lsb;

    always_comb begin
        d         = '0;
        d.pad_dly = {1'b0, lock_val_i[7:1]};
        d.rd_dly  = {1'b0, lock_val_i[7:1]} + 8'd1;
    end

    assign unused_lock_lsb = lock_val_i[0];
    assign delay_word_o    = d;

endmodule

// File: rtl/dll_cal_fsm.sv
module dll_cal_fsm
    import dll_cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [2:0]  timing_mode_i,
    input  logic [31:0] reg_rdata_i,
    input  logic [31:0] delay_word_i,
    input  logic        expired_i,
    output logic [7:0]  lock_val_o,
    output logic        tmr_clr_o,
    output logic        tmr_run_o,
    output logic        reg_wr_o,
    output logic        reg_rd_o,
    output logic [1:0]  reg_addr_o,
    output logic [31:0] reg_wdata_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        timeout_o
);
    cal_state_e state_q, state_d;
    logic [7:0] lock_q;
    logic       locked;
    logic       unused_rdata;

    assign locked       = reg_rdata_i[LOCK_FLAG_BIT];
    assign unused_rdata = ^reg_rdata_i[31:9];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i && is_ddr_mode(timing_mode_i)) state_d = ST_SET_BUS;
            ST_SET_BUS:  state_d = ST_WR_CTRL;
            ST_WR_CTRL:  state_d = ST_RD_LOCK;
            ST_RD_LOCK:  state_d = ST_CHK_LOCK;
            ST_CHK_LOCK: begin
                if (locked)         state_d = ST_WR_DELAY;
                else if (expired_i) state_d = ST_FIN_TO;
                else                state_d = ST_RD_LOCK;
            end
            ST_WR_DELAY: state_d = ST_FIN_OK;
            ST_FIN_OK:   state_d = ST_IDLE;
            ST_FIN_TO:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lock_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CHK_LOCK && locked) begin
                lock_q <= reg_rdata_i[7:0];
            end
        end
    end

    always_comb begin
        reg_wr_o    = 1'b0;
        reg_rd_o    = 1'b0;
        reg_addr_o  = RS_LOCK;
        reg_wdata_o = '0;
        unique case (state_q)
            ST_SET_BUS: begin
                reg_wr_o    = 1'b1;
                reg_addr_o  = RS_BUSSEL;
                reg_wdata_o = BUSSEL_DDR;
            end
            ST_WR_CTRL: begin
                reg_wr_o    = 1'b1;
                reg_addr_o  = RS_CTRL;
                reg_wdata_o = ctrl_word();
            end
            ST_RD_LOCK: begin
                reg_rd_o    = 1'b1;
                reg_addr_o  = RS_LOCK;
            end
            ST_WR_DELAY: begin
                reg_wr_o    = 1'b1;
                reg_addr_o  = RS_DELAY;
                reg_wdata_o = delay_word_i;
            end
            default: ;
        endcase
    end

    assign tmr_clr_o  = (state_q == ST_WR_CTRL);
    assign tmr_run_o  = (state_q == ST_RD_LOCK) || (state_q == ST_CHK_LOCK);
    assign lock_val_o = lock_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = (state_q == ST_FIN_OK);
    assign timeout_o  = (state_q == ST_FIN_TO);

    // R1: accepted DDR request leads straight to the DDR bus-mode write
    p_accept_ddr_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && is_ddr_mode(timing_mode_i)) |=>
        (reg_wr_o && reg_addr_o == RS_BUSSEL && reg_wdata_o[0]));

    // R2: control write follows the bus-mode write
    p_ctl_after_sel_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_o && reg_addr_o == RS_CTRL) |->
        $past(reg_wr_o && reg_addr_o == RS_BUSSEL));

    // R3: never read and write together
    p_no_dual_access_r3: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_o && reg_rd_o));

    // R4: timeout only once the budget has run out
    p_timeout_expired_r4: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> $past(expired_i && !locked));

    // R5: delay write only after a lock flag was returned
    p_dly_after_lock_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_o && reg_addr_o == RS_DELAY) |-> $past(locked));

    // R6: done is a single-cycle pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: busy holds until a result is reported
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && !timeout_o) |=> busy_o);

    // R8: non-DDR request leaves the block idle
    p_nonddr_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && !is_ddr_mode(timing_mode_i)) |=> !busy_o);

endmodule

// File: rtl/dll_cal_seq.sv
module dll_cal_seq
    import dll_cal_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int TIMEOUT_US = 4000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [2:0]  timing_mode_i,
    output logic        reg_wr_o,
    output logic        reg_rd_o,
    output logic [1:0]  reg_addr_o,
    output logic [31:0] reg_wdata_o,
    input  logic [31:0] reg_rdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        timeout_o
);
    localparam int LIMIT = CYC_PER_US * TIMEOUT_US;

    logic [7:0]  lock_val;
    logic [31:0] delay_word;
    logic        tmr_clr, tmr_run, expired;

    dll_poll_timer #(.LIMIT(LIMIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (tmr_clr),
        .run_i     (tmr_run),
        .expired_o (expired)
    );

    dll_delay_calc u_calc (
        .lock_val_i   (lock_val),
        .delay_word_o (delay_word)
    );

    dll_cal_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .timing_mode_i (timing_mode_i),
        .reg_rdata_i   (reg_rdata_i),
        .delay_word_i  (delay_word),
        .expired_i     (expired),
        .lock_val_o    (lock_val),
        .tmr_clr_o     (tmr_clr),
        .tmr_run_o     (tmr_run),
        .reg_wr_o      (reg_wr_o),
        .reg_rd_o      (reg_rd_o),
        .reg_addr_o    (reg_addr_o),
        .reg_wdata_o   (reg_wdata_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .timeout_o     (timeout_o)
    );

    // R6: success and failure never reported together
    p_excl_result_r6: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));

endmodule

// File: tb/test_dll_cal_seq.sv
module test_dll_cal_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CPU   = 2;
    localparam int TUS   = 10;
    localparam int LIMIT = CPU * TUS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;
    logic        busy, done, tmo;

    int compared = 0;
    int mismatched = 0;

    // DLL model state
    logic        model_clr = 1'b0;
    int          lock_n = 0;
    logic [7:0]  lock_val = 8'h00;
    int          lock_cnt = 0;
    logic        running = 1'b0;
    logic        locked;
    int          nsel = 0, nctl = 0, ndly = 0, seq = 0, sel_seq = 0, ctl_seq = 0;
    logic [31:0] sel_val = '0, ctl_val = '0, dly_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dll_cal_seq #(.CYC_PER_US(CPU), .TIMEOUT_US(TUS)) i_dll_cal_seq (
        .clk(clk), .rst(rst), .start_i(start), .timing_mode_i(mode),
        .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
        .busy_o(busy), .done_o(done), .timeout_o(tmo)
    );

    assign locked = running && (lock_cnt >= lock_n);

    always @(posedge clk) begin
        if (model_clr) begin
            nsel <= 0; nctl <= 0; ndly <= 0; seq <= 0;
            running <= 1'b0; lock_cnt <= 0;
        end else begin
            if (reg_wr) begin
                seq <= seq + 1;
                case (reg_addr)
                    2'd3: begin nsel <= nsel + 1; sel_val <= reg_wdata; sel_seq <= seq; end
                    2'd1: begin nctl <= nctl + 1; ctl_val <= reg_wdata; ctl_seq <= seq; end
                    2'd2: begin ndly <= ndly + 1; dly_val <= reg_wdata; end
                    default: ;
                endcase
            end
            if (reg_wr && reg_addr == 2'd1 && reg_wdata[25]) begin
                running <= 1'b1; lock_cnt <= 0;
            end else if (running && lock_cnt < lock_n) begin
                lock_cnt <= lock_cnt + 1;
            end
            if (reg_rd) reg_rdata <= (reg_addr == 2'd0) ? {23'd0, locked, lock_val} : 32'd0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int k_timeout();
        int k = 0;
        while (2*k + 1 < LIMIT) k++;
        return k;
    endfunction

    function automatic logic [31:0] exp_delay(input logic [7:0] v);
        logic [7:0] pad = {1'b0, v[7:1]};
        return {16'd0, pad + 8'd1, pad};
    endfunction

    localparam logic [31:0] EXP_CTL = (32'hF << 26) | (32'h1 << 25) | (32'h1 << 24)
                                    | (32'h01 << 16) | (32'h01 << 8) | 32'hC8;

    task automatic run_cal(input int n, input logic [7:0] v, input logic [2:0] m,
                           input bit poke, input bit full);
        bit got_done = 0, got_to = 0, exp_ok;
        @(negedge clk);
        lock_n = n; lock_val = v; model_clr = 1'b1;
        @(negedge clk);
        model_clr = 1'b0; start = 1'b1; mode = m;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", "busy after start", busy, 1);
        for (int i = 0; i < 4*LIMIT + 40; i++) begin
            start = (poke && i == 3);
            mode  = 3'd2;
            if (done || tmo) begin
                got_done = done; got_to = tmo;
                check(!(done && tmo), "R6", "done and timeout together", {done, tmo}, 0);
                check(busy == 1'b1, "R7", "busy on report cycle", busy, 1);
                @(negedge clk);
                check(!done && !tmo, "R6", "result pulse width", {done, tmo}, 0);
                check(!busy, "R7", "idle after report", busy, 0);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        exp_ok = ((n + 1) / 2) <= k_timeout();
        check(got_done == exp_ok && got_to == !exp_ok, exp_ok ? "R3" : "R4",
              $sformatf("outcome n=%0d", n), {got_done, got_to}, {exp_ok, !exp_ok});
        if (exp_ok) begin
            check(ndly == 1 && dly_val == exp_delay(v), "R5",
                  $sformatf("delay word lock=%0h", v), dly_val, exp_delay(v));
        end else begin
            check(ndly == 0, "R4", "delay writes on timeout", ndly, 0);
        end
        if (full) begin
            check(nsel == 1 && sel_val[0] == 1'b1, "R1", "bus select write", sel_val, 1);
            check(nctl == 1 && ctl_val == EXP_CTL, "R2", "control word", ctl_val, EXP_CTL);
            check(sel_seq == 0 && ctl_seq == 1, "R2", "write order",
                  {sel_seq[7:0], ctl_seq[7:0]}, 16'h0001);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: quiet after reset
        check(!busy && !done && !tmo && !reg_wr && !reg_rd, "R9", "reset outputs",
              {busy, done, tmo, reg_wr, reg_rd}, 0);

        // R3/R4: lock latency sweep across the budget boundary, both DDR modes
        for (int n = 0; n <= LIMIT + 5; n++) run_cal(n, 8'hA5, 3'd2, 0, 1);
        for (int n = LIMIT - 2; n <= LIMIT + 2; n++) run_cal(n, 8'h3C, 3'd3, 0, 1);

        // R5: all lock codes
        for (int v = 0; v < 256; v++) run_cal(3, v[7:0], 3'd2, 0, 0);

        // R7: second start while busy is ignored
        run_cal(8, 8'hFE, 3'd3, 1, 1);
        repeat (4) @(negedge clk);
        check(!busy && nsel == 1 && nctl == 1, "R7", "restart while busy",
              {busy, nsel[3:0], nctl[3:0]}, 9'h011);

        // R8: non-DDR modes
        for (int m = 0; m < 8; m++) begin
            if (m == 2 || m == 3) continue;
            @(negedge clk); model_clr = 1'b1;
            @(negedge clk); model_clr = 1'b0; start = 1'b1; mode = m[2:0];
            @(negedge clk); start = 1'b0;
            begin
                bit saw_busy = 0;
                for (int i = 0; i < 6; i++) begin
                    if (busy || reg_wr || reg_rd) saw_busy = 1;
                    @(negedge clk);
                end
                check(!saw_busy && nsel + nctl + ndly == 0, "R8",
                      $sformatf("mode %0d ignored", m), saw_busy, 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL R3 watchdog expired: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule